// File: doc/BRIEF.md
# Dual-Source Output Buffer Arbiter

This block merges two byte producers, a keyboard source and a pointer (auxiliary) source, into one host-visible output buffer. Each source holds its bytes in a small FIFO. A two-bit pending mask follows the "not empty" state of the two FIFOs. Bit 0 of the mask is the keyboard, bit 1 is the pointer. From that mask and an externally supplied mode byte, the block derives the buffer-full flags seen through the status register and the output port, and it drives one keyboard interrupt line and one pointer interrupt line.

When the host reads the data port, the block decides which FIFO to pop. Keyboard data always wins. The pointer FIFO is popped only when it is the sole source with data. The byte that was read appears on a registered read-data output one cycle after the read strobe. Command decoding sits outside this block, and the mode byte arrives as a plain input.

Top module: `obuf_arbiter`

## Requirements
- R1: The pending mask bit 0 is set exactly when the keyboard FIFO holds at least one byte. Bit 1 is set exactly when the pointer FIFO holds at least one byte. The mask changes in the same cycle as the FIFO contents.
- R2: `stat_obf` (status bit 0) and `port_obf` (output-port bit 4) are both 1 when either pending bit is set, and both 0 otherwise.
- R3: `stat_ptr_obf` (status bit 5) and `port_ptr_obf` (output-port bit 5) are 1 only when the mask equals pointer-only (binary 10). With both sources pending they are 0.
- R4: If the mask is pointer-only and mode bit 1 is 1, `irq_ptr` is 1 on the following clock edge. If mode bit 1 is 0, `irq_ptr` stays 0.
- R5: If the keyboard bit is pending, mode bit 0 is 1 and mode bit 4 (keyboard off) is 0, `irq_kbd` is 1 on the following clock edge. Otherwise `irq_kbd` is 0.
- R6: Both interrupt lines are 0 one edge after the mask is empty, and the two lines are never 1 together.
- R7: A read strobe pops the pointer FIFO only when the mask is pointer-only. Otherwise it pops the keyboard FIFO. The popped byte is on `rd_data` after the next clock edge.
- R8: A read strobe with an empty mask pops nothing and leaves `rd_data` at the last byte read.
- R9: Each FIFO holds DEPTH bytes (default 8) in first-in first-out order. A push to a full FIFO with no pop in the same cycle is dropped.
- R10: The interrupt lines follow a change of the mode byte on the next edge, even when the mask does not change.
- R11: After reset both FIFOs are empty, every flag and interrupt is 0, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_push | input | 1 | Keyboard source byte strobe |
| kbd_byte | input | 8 | Keyboard source byte |
| ptr_push | input | 1 | Pointer source byte strobe |
| ptr_byte | input | 8 | Pointer source byte |
| mode_in | input | 8 | Mode byte: bit 0 keyboard irq enable, bit 1 pointer irq enable, bit 4 keyboard off |
| host_rd | input | 1 | Host data-port read strobe |
| rd_data | output | 8 | Byte returned by the last read |
| stat_obf | output | 1 | Status bit 0: output buffer full |
| stat_ptr_obf | output | 1 | Status bit 5: pointer data in buffer |
| port_obf | output | 1 | Output-port bit 4: output buffer full |
| port_ptr_obf | output | 1 | Output-port bit 5: pointer data in buffer |
| irq_kbd | output | 1 | Keyboard interrupt, registered |
| irq_ptr | output | 1 | Pointer interrupt, registered |

## Verification
The properties assume that the strobes are single-cycle pulses, driven only while reset is released, and that the mode byte is stable around each clock edge. They do not assume any relation between pushes and reads. A push and a read of the same FIFO in one cycle is legal.

The stimulus changes every input on the falling edge, which keeps it inside these assumptions. It keeps a reference queue per source so that an expected byte exists for every read. It deliberately overfills one FIFO and reads an empty buffer to reach the drop and hold cases.

// File: rtl/obuf_pkg.sv
package obuf_pkg;
    localparam int BYTE_W = 8;
    // Mode byte bit positions
    localparam int MODE_KBD_IRQ_EN = 0;
    localparam int MODE_PTR_IRQ_EN = 1;
    localparam int MODE_KBD_OFF    = 4;
    // Pending mask encoding
    localparam int PEND_KBD_BIT = 0;
    localparam int PEND_PTR_BIT = 1;
    localparam logic [1:0] PEND_PTR_ONLY = 2'b10;

    typedef struct packed {
        logic irq_kbd;
        logic irq_ptr;
    } irq_pair_t;
endpackage

// File: rtl/obuf_fifo.sv
module obuf_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             not_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wr_ptr;
        logic [AW-1:0]               rd_ptr;
        logic [CW-1:0]               count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.count != '0);
        do_push = push && ((st_q.count != FULLC) || do_pop);
        if (do_push) begin
            st_d.mem[st_q.wr_ptr] = din;
            st_d.wr_ptr = (st_q.wr_ptr == LAST) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST) ? '0 : st_q.rd_ptr + 1'b1;
        end
        if (do_push && !do_pop)      st_d.count = st_q.count + 1'b1;
        else if (do_pop && !do_push) st_d.count = st_q.count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head      = st_q.mem[st_q.rd_ptr];
    assign not_empty = (st_q.count != '0);

    // R9: occupancy never exceeds the depth
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULLC);
    // R9: a push into a full FIFO without a pop is dropped
    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == FULLC && push && !pop) |=> $stable(st_q.count));
endmodule

// File: rtl/obuf_sel.sv
module obuf_sel
    import obuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pending,
    input  logic [BYTE_W-1:0] mode,
    output logic              any_full,
    output logic              ptr_only,
    output logic              irq_kbd,
    output logic              irq_ptr
);
    irq_pair_t irq_d, irq_q;
    logic      unused_mode;

    assign unused_mode = ^{mode[BYTE_W-1:5], mode[3:2]};

    always_comb begin
        any_full = |pending;
        ptr_only = (pending == PEND_PTR_ONLY);
        irq_d    = '0;
        if (ptr_only) begin
            irq_d.irq_ptr = mode[MODE_PTR_IRQ_EN];
        end else if (any_full) begin
            irq_d.irq_kbd = mode[MODE_KBD_IRQ_EN] && !mode[MODE_KBD_OFF];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_kbd = irq_q.irq_kbd;
    assign irq_ptr = irq_q.irq_ptr;

    // R6: interrupt lines are mutually exclusive
    p_irq_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_kbd && irq_ptr));
    // R6: nothing pending drops both lines on the next edge
    p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == 2'b00) |=> (!irq_kbd && !irq_ptr));
    // R4: pointer-only with its enable raises the pointer line
    p_ptr_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == PEND_PTR_ONLY && mode[MODE_PTR_IRQ_EN]) |=> irq_ptr);
    // R5: keyboard pending, enabled and not off raises the keyboard line
    p_kbd_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending[PEND_KBD_BIT] && mode[MODE_KBD_IRQ_EN] && !mode[MODE_KBD_OFF])
        |=> irq_kbd);
    // R10: keyboard-off bit masks the keyboard line on the next edge
    p_kbd_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode[MODE_KBD_OFF] |=> !irq_kbd);
endmodule

// File: rtl/obuf_arbiter.sv
module obuf_arbiter
    import obuf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_push,
    input  logic [BYTE_W-1:0] kbd_byte,
    input  logic              ptr_push,
    input  logic [BYTE_W-1:0] ptr_byte,
    input  logic [BYTE_W-1:0] mode_in,
    input  logic              host_rd,
    output logic [BYTE_W-1:0] rd_data,
    output logic              stat_obf,
    output logic              stat_ptr_obf,
    output logic              port_obf,
    output logic              port_ptr_obf,
    output logic              irq_kbd,
    output logic              irq_ptr
);
    localparam int NSRC = 2;

    typedef struct packed {
        logic [BYTE_W-1:0] rd_byte;
    } rd_st_t;

    logic [NSRC-1:0]             push_v, pop_v, pending;
    logic [NSRC-1:0][BYTE_W-1:0] din_v, head_v;
    logic                        any_full, ptr_only;
    rd_st_t                      rd_d, rd_q;

    assign push_v[PEND_KBD_BIT] = kbd_push;
    assign push_v[PEND_PTR_BIT] = ptr_push;
    assign din_v[PEND_KBD_BIT]  = kbd_byte;
    assign din_v[PEND_PTR_BIT]  = ptr_byte;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        obuf_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_v[s]),
            .din       (din_v[s]),
            .pop       (pop_v[s]),
            .head      (head_v[s]),
            .not_empty (pending[s])
        );
    end

    obuf_sel u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending  (pending),
        .mode     (mode_in),
        .any_full (any_full),
        .ptr_only (ptr_only),
        .irq_kbd  (irq_kbd),
        .irq_ptr  (irq_ptr)
    );

    always_comb begin
        rd_d  = rd_q;
        pop_v = '0;
        if (host_rd) begin
            if (ptr_only) begin
                pop_v[PEND_PTR_BIT] = 1'b1;
                rd_d.rd_byte        = head_v[PEND_PTR_BIT];
            end else if (pending[PEND_KBD_BIT]) begin
                pop_v[PEND_KBD_BIT] = 1'b1;
                rd_d.rd_byte        = head_v[PEND_KBD_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data      = rd_q.rd_byte;
    assign stat_obf     = any_full;
    assign port_obf     = any_full;
    assign stat_ptr_obf = ptr_only;
    assign port_ptr_obf = ptr_only;

    // R3: pointer flag implies the general full flag
    p_ptr_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_ptr_obf |-> stat_obf);
    // R8: a read of an empty buffer holds the returned byte
    p_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && pending == 2'b00) |=> $stable(rd_data));
    // R7: with keyboard data pending a read never pops the pointer FIFO
    p_kbd_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pending[PEND_KBD_BIT] |-> !pop_v[PEND_PTR_BIT]);
endmodule

// File: tb/test_obuf_arbiter.sv
`timescale 1ns/1ps
module test_obuf_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kbd_push = 1'b0, ptr_push = 1'b0, host_rd = 1'b0;
    logic [7:0] kbd_byte = '0, ptr_byte = '0, mode_in = '0;
    logic [7:0] rd_data;
    logic       stat_obf, stat_ptr_obf, port_obf, port_ptr_obf, irq_kbd, irq_ptr;

    int checks = 0;
    int fails  = 0;
    logic [7:0] kq[$];
    logic [7:0] pq[$];
    logic [7:0] exp_q[$];
    logic [7:0] last_rd = 8'h00;

    always #4 clk = ~clk;

    obuf_arbiter i_obuf_arbiter (
        .clk(clk), .rst_n(rst_n),
        .kbd_push(kbd_push), .kbd_byte(kbd_byte),
        .ptr_push(ptr_push), .ptr_byte(ptr_byte),
        .mode_in(mode_in), .host_rd(host_rd), .rd_data(rd_data),
        .stat_obf(stat_obf), .stat_ptr_obf(stat_ptr_obf),
        .port_obf(port_obf), .port_ptr_obf(port_ptr_obf),
        .irq_kbd(irq_kbd), .irq_ptr(irq_ptr)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compares every read result one edge after the strobe
    initial begin
        forever begin
            @(posedge clk);
            if (host_rd) begin
                #2;
                if (exp_q.size() == 0) chk(8'hxx, 8'h00, "R7 scoreboard underflow");
                else chk(rd_data, exp_q.pop_front(), "R7/R8 read byte");
            end
        end
    end

    task automatic push(input bit to_ptr, input logic [7:0] b);
        @(negedge clk);
        if (to_ptr) begin ptr_push = 1'b1; ptr_byte = b; if (pq.size() < 8) pq.push_back(b); end
        else        begin kbd_push = 1'b1; kbd_byte = b; if (kq.size() < 8) kq.push_back(b); end
        @(negedge clk);
        ptr_push = 1'b0; kbd_push = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        host_rd = 1'b1;
        if (kq.size() != 0)      last_rd = kq.pop_front();
        else if (pq.size() != 0) last_rd = pq.pop_front();
        exp_q.push_back(last_rd);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // One idle edge so the registered interrupts settle, then compare all flags
    task automatic check_state(input string tag);
        logic anyp, ponly, ek, ep;
        @(negedge clk);
        anyp  = (kq.size() != 0) || (pq.size() != 0);
        ponly = (kq.size() == 0) && (pq.size() != 0);
        ek = (kq.size() != 0) && mode_in[0] && !mode_in[4];
        ep = ponly && mode_in[1];
        chk({7'b0, stat_obf},     {7'b0, anyp},  {"R1 R2 stat_obf ", tag});
        chk({7'b0, port_obf},     {7'b0, anyp},  {"R2 port_obf ", tag});
        chk({7'b0, stat_ptr_obf}, {7'b0, ponly}, {"R3 stat_ptr_obf ", tag});
        chk({7'b0, port_ptr_obf}, {7'b0, ponly}, {"R3 port_ptr_obf ", tag});
        chk({7'b0, irq_kbd},      {7'b0, ek},    {"R5 irq_kbd ", tag});
        chk({7'b0, irq_ptr},      {7'b0, ep},    {"R4 R6 irq_ptr ", tag});
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check_state("R11 reset");
        chk(rd_data, 8'h00, "R11 rd_data after reset");

        mode_in = 8'h03;
        push(0, 8'hA1);
        check_state("kbd only");
        push(1, 8'hB1);
        check_state("both pending, kbd priority R3");
        rd();                               // R7 keyboard first
        check_state("pointer only R4");
        rd();                               // R7 pointer popped
        check_state("empty R6");
        rd();                               // R8 empty read holds B1
        check_state("after empty read R8");
        chk(rd_data, 8'hB1, "R8 hold last byte");

        // R10: mode change alone moves the interrupt
        mode_in = 8'h13;
        push(0, 8'hC3);
        check_state("kbd off R10");
        mode_in = 8'h03;
        check_state("kbd back on R10");
        mode_in = 8'h02;
        check_state("kbd irq disabled R5");
        rd();

        // R4: pointer-only without its enable
        mode_in = 8'h01;
        push(1, 8'hD4);
        check_state("ptr irq disabled R4");
        mode_in = 8'h02;
        check_state("ptr irq enabled R10");
        rd();

        // R9: overfill keyboard FIFO, order and drop
        mode_in = 8'h03;
        for (int i = 0; i < 10; i++) push(0, 8'h10 + 8'(i));
        check_state("kbd full R9");
        push(1, 8'h77);
        for (int i = 0; i < 8; i++) rd();   // R9 order, 0x18/0x19 dropped
        check_state("kbd drained ptr left R9");
        rd();
        rd();                               // R8 empty again
        check_state("final empty R6");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule